// File: doc/BRIEF.md
# CAN Controller Operating Mode Sequencer

This block holds the operating mode of a CAN controller and moves it between sleep, initialization and normal operation on software request. Software drives two request bits and polls two acknowledge flags; a mode change is never immediate. It first enters a pending phase and completes only when its own completion condition is met. Entry to sleep or initialization waits for a hardware-ready acknowledge. Entry to normal operation waits for the bus to be idle, which here means a run of recessive bits seen at successive sample points.

The sample-point strobe and the sampled receive level come from the bit-timing logic. A saturating counter tracks recessive samples. It restarts whenever a new pending phase begins, and any dominant sample clears it. If the requests change while a change is pending, the pending change is dropped and the new request is taken up on the following cycle. The flags keep showing the last mode that was fully entered. A 2-bit mode code and a one-cycle change pulse are also provided.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the block is in sleep mode: `sleep_ack`=1, `init_ack`=0, `mode_code`=00, `mode_chg`=0.
- R2: The flags follow the entered mode: sleep gives `sleep_ack`=1, `init_ack`=0; initialization gives 0,1; normal gives 0,0.
- R3: With `req_init`=1 and `req_sleep`=0, from sleep or normal, a pending phase starts on the next edge. Initialization is entered on the first later edge at which `hw_ack`=1.
- R4: With `req_sleep`=1 and `req_init`=0, from initialization or normal, a pending phase starts on the next edge. Sleep is entered on the first later edge at which `hw_ack`=1.
- R5: With both requests 0, from sleep or initialization, a pending phase starts and clears the idle count. Each edge with `smp_stb`=1 and `rx_lvl`=1 adds one, and the count saturates at 11. Normal mode is entered on the edge after the count reaches 11.
- R6: An edge with `smp_stb`=1 and `rx_lvl`=0 sets the idle count to 0. An edge with `smp_stb`=0 leaves the count unchanged, whatever `rx_lvl` is.
- R7: If the decoded request differs from the pending target, the pending phase is dropped and the flags keep the previous mode. The new request starts its own pending phase on the next edge.
- R8: With both requests 1, no mode change happens and any pending phase is dropped.
- R9: `hw_ack` has no effect unless a sleep or initialization change is pending.
- R10: `mode_code` is 00 for sleep, 01 for initialization and 10 for normal.
- R11: `mode_chg` is 1 for exactly the one cycle in which the entered mode has just changed, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_sleep | input | 1 | Software request for sleep mode |
| req_init | input | 1 | Software request for initialization mode |
| smp_stb | input | 1 | One-cycle strobe at each bit sample point |
| rx_lvl | input | 1 | Sampled receive line level, 1 = recessive |
| hw_ack | input | 1 | Hardware-ready acknowledge for sleep/initialization entry |
| sleep_ack | output | 1 | Sleep mode entered |
| init_ack | output | 1 | Initialization mode entered |
| mode_code | output | 2 | Entered mode: 00 sleep, 01 init, 10 normal |
| mode_chg | output | 1 | One-cycle pulse on each completed mode change |

## Verification
The assertions assume that the requests, `hw_ack`, `smp_stb` and `rx_lvl` are synchronous to `clk` and stable around each rising edge. They also assume `smp_stb` is a single-cycle pulse that never overlaps reset release. The stimulus changes every input just after a falling edge. It holds the requests at the current mode while reset is released and for a few cycles after it, so the internal reset release cannot coincide with a transition. Only after that does it start pending phases, drop them and issue conflicting requests.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP = 2'b00,
    MODE_INIT  = 2'b01,
    MODE_NORM  = 2'b10
  } op_mode_e;

  typedef struct packed {
    logic     valid;
    op_mode_e dst;
  } pend_t;

endpackage

// File: rtl/can_rst_sync.sv
module can_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/can_idle_detect.sv
module can_idle_detect #(
  parameter int IDLE_BITS = 11,
  localparam int CNT_W = $clog2(IDLE_BITS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic smp_stb,
  input  logic rx_lvl,
  output logic bus_idle
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(IDLE_BITS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = restart || smp_stb;
    cnt_d  = cnt_q;
    if (restart)             cnt_d = '0;
    else if (!rx_lvl)        cnt_d = '0;
    else if (cnt_q != FULL)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign bus_idle = (cnt_q == FULL);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  p_dom_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !rx_lvl) |=> (cnt_q == '0));
  p_no_stb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_stb && !restart) |=> $stable(cnt_q));
  p_restart_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !bus_idle);
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_sleep,
  input  logic     req_init,
  input  logic     hw_ack,
  input  logic     bus_idle,
  output op_mode_e cur_mode,
  output logic     wait_start,
  output logic     done
);
  op_mode_e cur_q, cur_d;
  pend_t    pend_q, pend_d;
  logic     tgt_ok;
  op_mode_e tgt;
  logic     cond_met;

  always_comb begin
    tgt_ok = 1'b1;
    tgt    = MODE_NORM;
    unique case ({req_sleep, req_init})
      2'b00: tgt = MODE_NORM;
      2'b10: tgt = MODE_SLEEP;
      2'b01: tgt = MODE_INIT;
      default: tgt_ok = 1'b0;
    endcase
  end

  assign cond_met = (pend_q.dst == MODE_NORM) ? bus_idle : hw_ack;

  always_comb begin
    pend_d     = pend_q;
    cur_d      = cur_q;
    wait_start = 1'b0;
    done       = 1'b0;
    if (pend_q.valid) begin
      if (!tgt_ok || (tgt != pend_q.dst)) begin
        pend_d.valid = 1'b0;
      end else if (cond_met) begin
        done         = 1'b1;
        cur_d        = pend_q.dst;
        pend_d.valid = 1'b0;
      end
    end else if (tgt_ok && (tgt != cur_q)) begin
      pend_d.valid = 1'b1;
      pend_d.dst   = tgt;
      wait_start   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= MODE_SLEEP;
      pend_q <= '{valid: 1'b0, dst: MODE_SLEEP};
    end else begin
      pend_q <= pend_d;
      if (done) cur_q <= cur_d;
    end
  end

  assign cur_mode = cur_q;

  p_done_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pend_q.valid);
  p_conflict_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sleep && req_init) |=> !pend_q.valid);
  p_no_pend_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q.valid) |=> (cur_q == $past(cur_q)));
endmodule

// File: rtl/can_mode_status.sv
module can_mode_status
  import can_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  op_mode_e   cur_mode,
  input  logic       done,
  output logic       sleep_ack,
  output logic       init_ack,
  output logic [1:0] mode_code,
  output logic       mode_chg
);
  logic chg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= 1'b0;
    else        chg_q <= done;
  end

  assign sleep_ack = (cur_mode == MODE_SLEEP);
  assign init_ack  = (cur_mode == MODE_INIT);
  assign mode_code = cur_mode;
  assign mode_chg  = chg_q;

  p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_ack && init_ack));
  p_pulse_on_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code != $past(mode_code)) |-> mode_chg);
  p_pulse_only_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> (mode_code != $past(mode_code)));
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int IDLE_BITS  = 11,
  parameter int SYNC_STAGE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_sleep,
  input  logic       req_init,
  input  logic       smp_stb,
  input  logic       rx_lvl,
  input  logic       hw_ack,
  output logic       sleep_ack,
  output logic       init_ack,
  output logic [1:0] mode_code,
  output logic       mode_chg
);
  logic     rst_n_i;
  logic     bus_idle;
  logic     wait_start;
  logic     done;
  op_mode_e cur_mode;

  can_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  can_idle_detect #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst_n(rst_n_i), .restart(wait_start),
    .smp_stb(smp_stb), .rx_lvl(rx_lvl), .bus_idle(bus_idle));

  can_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_i), .req_sleep(req_sleep), .req_init(req_init),
    .hw_ack(hw_ack), .bus_idle(bus_idle), .cur_mode(cur_mode),
    .wait_start(wait_start), .done(done));

  can_mode_status u_stat (
    .clk(clk), .rst_n(rst_n_i), .cur_mode(cur_mode), .done(done),
    .sleep_ack(sleep_ack), .init_ack(init_ack),
    .mode_code(mode_code), .mode_chg(mode_chg));

  p_init_by_ack_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mode_code == 2'b01 && $past(mode_code) != 2'b01)
      |-> ($past(hw_ack) && $past(req_init) && !$past(req_sleep)));
  p_sleep_by_ack_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mode_code == 2'b00 && $past(mode_code) != 2'b00)
      |-> ($past(hw_ack) && $past(req_sleep) && !$past(req_init)));
  p_norm_by_sync_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mode_code == 2'b10 && $past(mode_code) != 2'b10)
      |-> ($past(bus_idle) && !$past(req_sleep) && !$past(req_init)));
  p_code_legal_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    mode_code != 2'b11);
  p_both_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_sleep && req_init) |=> (mode_code == $past(mode_code)));
endmodule

// File: tb/tb_can_mode_seq.sv
module tb_can_mode_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic req_sleep, req_init, smp_stb, rx_lvl, hw_ack;
  logic sleep_ack, init_ack, mode_chg;
  logic [1:0] mode_code;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  // reference state: 0 sleep, 1 init, 2 normal
  int m_mode, m_pdst, m_cnt;
  bit m_pv, m_chg;

  always #5 clk = ~clk;

  can_mode_seq dut (
    .clk(clk), .rst_n(rst_n), .req_sleep(req_sleep), .req_init(req_init),
    .smp_stb(smp_stb), .rx_lvl(rx_lvl), .hw_ack(hw_ack),
    .sleep_ack(sleep_ack), .init_ack(init_ack),
    .mode_code(mode_code), .mode_chg(mode_chg));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pv = 0; m_pdst = 0; m_cnt = 0; m_chg = 0;
    end else begin
      int tgt;
      bit ok, start, fin;
      ok = 1; start = 0; fin = 0;
      if (!req_sleep && !req_init) tgt = 2;
      else if (req_sleep && !req_init) tgt = 0;
      else if (!req_sleep && req_init) tgt = 1;
      else begin tgt = -1; ok = 0; end
      if (m_pv) begin
        if (!ok || tgt != m_pdst) m_pv = 0;
        else if ((m_pdst == 2) ? (m_cnt == 11) : hw_ack) fin = 1;
      end else if (ok && tgt != m_mode) begin
        start = 1;
      end
      if (start) m_cnt = 0;
      else if (smp_stb) m_cnt = rx_lvl ? ((m_cnt < 11) ? m_cnt + 1 : 11) : 0;
      if (fin) begin m_mode = m_pdst; m_pv = 0; end
      if (start) begin m_pv = 1; m_pdst = tgt; end
      m_chg = fin;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk(mode_code == m_mode[1:0], "R10 mode_code", mode_code, m_mode);
    chk(sleep_ack == (m_mode == 0) && init_ack == (m_mode == 1),
        "R2 flags", {sleep_ack, init_ack}, {m_mode == 0, m_mode == 1});
    chk(mode_chg == m_chg, "R11 mode_chg", mode_chg, m_chg);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobes(input int n, input bit lvl);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); smp_stb = 1'b1; rx_lvl = lvl;
      @(negedge clk); smp_stb = 1'b0; rx_lvl = 1'b0;
    end
  endtask

  task automatic expect_mode(input int m, input string tag);
    chk(mode_code == m[1:0], tag, mode_code, m);
  endtask

  initial begin
    rst_n = 1'b0; req_sleep = 1'b1; req_init = 1'b0;
    smp_stb = 1'b0; rx_lvl = 1'b1; hw_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(sleep_ack && !init_ack && mode_code == 2'b00 && !mode_chg, "R1 reset",
        {sleep_ack, init_ack, mode_code, mode_chg}, 4'b1000);
    rst_n = 1'b1;
    idle(5);
    chk(sleep_ack && !init_ack, "R1 after release", {sleep_ack, init_ack}, 2'b10);

    // R9: ack with nothing pending
    hw_ack = 1'b1; idle(4); hw_ack = 1'b0;
    expect_mode(0, "R9 ack ignored");

    // R3: sleep -> init, waits for ack
    req_sleep = 1'b0; req_init = 1'b1; idle(6);
    expect_mode(0, "R3 waits for ack");
    hw_ack = 1'b1; idle(2); hw_ack = 1'b0; idle(1);
    expect_mode(1, "R3 init entered");
    chk(init_ack && !sleep_ack, "R2 init flags", {sleep_ack, init_ack}, 2'b01);

    // R5/R6: init -> normal, interrupted by dominant and unstrobed cycles
    req_init = 1'b0; idle(2);
    strobes(10, 1'b1);
    strobes(1, 1'b0);
    @(negedge clk); rx_lvl = 1'b1; idle(6); rx_lvl = 1'b0;
    strobes(10, 1'b1);
    idle(2);
    expect_mode(1, "R6 dominant restarts count");
    strobes(1, 1'b1); idle(2);
    expect_mode(2, "R5 normal after 11 recessive");
    chk(!sleep_ack && !init_ack, "R2 normal flags", {sleep_ack, init_ack}, 2'b00);

    // R8: both requests with ack held
    req_sleep = 1'b1; req_init = 1'b1; hw_ack = 1'b1; idle(8);
    expect_mode(2, "R8 both set holds");
    hw_ack = 1'b0;

    // R4: normal -> sleep
    req_init = 1'b0; idle(3); hw_ack = 1'b1; idle(2); hw_ack = 1'b0; idle(1);
    expect_mode(0, "R4 sleep from normal");

    // R7: pending init abandoned for normal
    req_sleep = 1'b0; req_init = 1'b1; idle(4);
    req_init = 1'b0; idle(1);
    hw_ack = 1'b1; idle(2); hw_ack = 1'b0;
    expect_mode(0, "R7 flags hold previous mode");
    strobes(20, 1'b1); idle(2);
    expect_mode(2, "R7 new request completes");

    // R3 from normal, R4 from init
    req_init = 1'b1; hw_ack = 1'b1; idle(4);
    expect_mode(1, "R3 init from normal");
    req_init = 1'b0; req_sleep = 1'b1; idle(4);
    expect_mode(0, "R4 sleep from init");
    hw_ack = 1'b0;

    // R5: saturation with sleep -> normal, strobe on entry cycle
    req_sleep = 1'b0; smp_stb = 1'b1; rx_lvl = 1'b1;
    @(negedge clk); smp_stb = 1'b0;
    strobes(30, 1'b1); idle(3);
    expect_mode(2, "R5 sleep to normal");
    idle(4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule